// File: doc/BRIEF.md
# Program Counter Update Unit

This block holds the program counter of a multi-cycle processor and decides, cycle by cycle, whether it changes and what it changes to. The control sequencer drives a two-bit source select and two write strobes. One strobe forces a write. The other requests a write that only happens when the ALU reports a zero result, which is how a branch-if-equal is resolved.

The next value comes from one of four places. The first is the combinational ALU result, which carries the incremented PC during fetch. The second is the ALU output register, which carries a branch target computed in an earlier step. The third is a jump target built from the instruction word. The fourth is a fixed handler address that a trap sequence can load. The jump target is formed from three parts, from most to least significant: the top four bits of the current PC, the 26-bit index field of the instruction, and two zero bits.

Top module: `pc_update`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` becomes 0 on that edge, whatever the strobes and the select carry.
- R2: With `pc_sel` = 2'b00 and an effective write, `pc_q` takes `alu_now` on the next edge.
- R3: With `pc_sel` = 2'b01 and an effective write, `pc_q` takes `alu_held` on the next edge.
- R4: With `pc_sel` = 2'b10 and an effective write, `pc_q` takes {old `pc_q`[31:28], `instr`[25:0], 2'b00}. The bits `instr`[31:26] have no effect on the result.
- R5: With `pc_sel` = 2'b11 and an effective write, `pc_q` takes the parameter `TRAP_ADDR`, which defaults to 32'h0000_0100.
- R6: When `wr_force` is high, the write happens whatever the value of `zero`.
- R7: When `wr_force` is low and `wr_branch` is high, the write happens only if `zero` is high. With `zero` low, `pc_q` keeps its value.
- R8: When `wr_force` is low and `wr_branch` is low, `pc_q` keeps its value, whatever the data inputs and the select carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alu_now | input | 32 | Combinational ALU result (source 0) |
| alu_held | input | 32 | ALU output register (source 1) |
| instr | input | 32 | Instruction register, supplies the jump index field |
| pc_sel | input | 2 | Next-PC source select |
| wr_force | input | 1 | Unconditional PC write strobe |
| wr_branch | input | 1 | PC write strobe that applies only when `zero` is high |
| zero | input | 1 | ALU zero flag |
| pc_q | output | 32 | Registered program counter |

## Verification
The assertions check on every cycle that reset clears the counter. They also check that the counter holds whenever neither strobe applies, including a branch whose zero flag is low. Finally they check that each source, when written, arrives on the next edge, with the jump keeping the old upper bits and clearing the two low bits. The bench's scenarios are what show the select and the strobes working together under random data. They also show that the unused upper instruction bits truly have no effect, that a forced write ignores the zero flag, and that a reset in mid-run wins over active strobes.

// File: rtl/pc_update.sv
module pc_update #(
  parameter int WIDTH = 32,
  parameter int IDX_BITS = 26,
  parameter int ALIGN = 2,
  parameter logic [31:0] TRAP_ADDR = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] alu_now,
  input  logic [WIDTH-1:0] alu_held,
  input  logic [WIDTH-1:0] instr,
  input  logic [1:0]       pc_sel,
  input  logic             wr_force,
  input  logic             wr_branch,
  input  logic             zero,
  output logic [WIDTH-1:0] pc_q
);
  localparam int TOP = WIDTH - IDX_BITS - ALIGN;

  logic [WIDTH-1:0] jump_tgt;
  logic [WIDTH-1:0] pc_next;
  logic             pc_en;
  logic             unused_instr_hi;

  assign jump_tgt = {pc_q[WIDTH-1 -: TOP], instr[IDX_BITS-1:0], {ALIGN{1'b0}}};
  assign unused_instr_hi = ^instr[WIDTH-1:IDX_BITS];
  assign pc_en = wr_force | (wr_branch & zero);

  always_comb begin
    case (pc_sel)
      2'd0:    pc_next = alu_now;
      2'd1:    pc_next = alu_held;
      2'd2:    pc_next = jump_tgt;
      default: pc_next = TRAP_ADDR[WIDTH-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        pc_q <= '0;
    else if (pc_en) pc_q <= pc_next;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> pc_q == '0);

  assert_src_alu_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_force && pc_sel == 2'd0) |=> pc_q == $past(alu_now));

  assert_src_held_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_force && pc_sel == 2'd1) |=> pc_q == $past(alu_held));

  assert_jump_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_force && pc_sel == 2'd2) |=>
      (pc_q[WIDTH-1 -: TOP] == $past(pc_q[WIDTH-1 -: TOP]) && pc_q[ALIGN-1:0] == '0));

  assert_trap_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_force && pc_sel == 2'd3) |=> pc_q == TRAP_ADDR[WIDTH-1:0]);

  assert_branch_untaken_R7: assert property (@(posedge clk) disable iff (rst)
    (!wr_force && wr_branch && !zero) |=> $stable(pc_q));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!wr_force && !wr_branch) |=> $stable(pc_q));
endmodule

// File: tb/pc_update_tb.sv
module pc_update_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TRAP = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] alu_now, alu_held, instr;
  logic [1:0]  pc_sel;
  logic        wr_force, wr_branch, zero;
  logic [31:0] pc_q;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] model_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_update u_dut (
    .clk(clk), .rst(rst), .alu_now(alu_now), .alu_held(alu_held),
    .instr(instr), .pc_sel(pc_sel), .wr_force(wr_force),
    .wr_branch(wr_branch), .zero(zero), .pc_q(pc_q)
  );

  function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] a,
                                       input logic [31:0] h, input logic [31:0] ir,
                                       input logic [31:0] cur);
    case (s)
      2'd0: pick = a;
      2'd1: pick = h;
      2'd2: pick = {cur[31:28], ir[25:0], 2'b00};
      default: pick = TRAP;
    endcase
  endfunction

  function automatic logic [31:0] expect_pc(input logic r, input logic f, input logic b,
                                            input logic z, input logic [1:0] s,
                                            input logic [31:0] a, input logic [31:0] h,
                                            input logic [31:0] ir, input logic [31:0] cur);
    if (r) expect_pc = 32'h0;
    else if (f || (b && z)) expect_pc = pick(s, a, h, ir, cur);
    else expect_pc = cur;
  endfunction

  function automatic string tag(input logic r, input logic f, input logic b,
                                input logic z, input logic [1:0] s);
    if (r) return "R1";
    if (!f && !b) return "R8";
    if (!f && b && !z) return "R7";
    case (s)
      2'd0: return (f && !z) ? "R6/R2" : "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic apply(input logic r, input logic f, input logic b, input logic z,
                       input logic [1:0] s, input logic [31:0] a, input logic [31:0] h,
                       input logic [31:0] ir);
    logic [31:0] exp_v;
    string t;
    @(negedge clk);
    rst = r; wr_force = f; wr_branch = b; zero = z; pc_sel = s;
    alu_now = a; alu_held = h; instr = ir;
    exp_v = expect_pc(r, f, b, z, s, a, h, ir, model_pc);
    t = tag(r, f, b, z, s);
    @(posedge clk);
    #1;
    vectors++;
    if (pc_q !== exp_v) begin
      fails++;
      $display("FAIL %s: pc_q=%h expected=%h", t, pc_q, exp_v);
    end
    model_pc = exp_v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1; wr_force = 0; wr_branch = 0; zero = 0; pc_sel = 0;
    alu_now = 0; alu_held = 0; instr = 0;
    model_pc = 0;
    // R1: reset state with every strobe active
    apply(1, 1, 1, 1, 2'd1, 32'hDEAD_BEEF, 32'h1234_5678, 32'hFFFF_FFFF);
    // R2: fetch-style increment
    apply(0, 1, 0, 0, 2'd0, 32'h0000_0004, 32'h0, 32'h0);
    // R8: no strobes, all data toggling
    apply(0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h5555_5555);
    // R7: branch not taken
    apply(0, 0, 1, 0, 2'd1, 32'h0, 32'h0000_0080, 32'h0);
    // R7: branch taken to held target
    apply(0, 0, 1, 1, 2'd1, 32'h0, 32'hF000_0080, 32'h0);
    // R4: jump with upper instr bits set, keep old PC[31:28]=F
    apply(0, 1, 0, 0, 2'd2, 32'h0, 32'h0, 32'hFC00_0001);
    // R4: same index field with different upper bits -> same result
    apply(0, 1, 0, 0, 2'd2, 32'h0, 32'h0, 32'h0000_0001);
    // R5: trap address
    apply(0, 1, 0, 1, 2'd3, 32'h1, 32'h2, 32'h3);
    // R6: forced write ignores zero=0, and with branch strobe too
    apply(0, 1, 0, 0, 2'd0, 32'h8765_4320, 32'h0, 32'h0);
    apply(0, 1, 1, 0, 2'd1, 32'h0, 32'h3333_3330, 32'h0);
    // R1: mid-run reset beats strobes
    apply(1, 1, 0, 1, 2'd0, 32'h7777_7777, 32'h0, 32'h0);
    for (int i = 0; i < 3000; i++) begin
      apply(($urandom % 64) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
            2'($urandom % 4), $urandom, $urandom, $urandom);
    end
    finish_run();
  end
endmodule